// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block reads a processor's boot-time configuration from an external serial mode source once the supply has been declared stable. While power-good is high and the load has not finished, it runs an 8-bit divider on the system clock. The divider's top bit is driven out as a slow mode clock at one 256th of the system clock rate. One mode-data bit is captured at each rising edge of the mode clock, and the block gathers 256 bits into a parallel configuration word.

When the last bit has been captured, the block raises a done flag and publishes the word. It also checks three bits that must read as one and flags an error if any of them is zero. It produces an effective endianness in one of two ways: a selector bit in the stream either takes the value from another stream bit or leaves the choice to an external endian pin.

Dropping power-good or raising cold reset abandons any load in progress. The next rise of power-good starts a fresh load from bit 0.

Top module: `boot_cfg_loader`

## Requirements
- R1: While `cold_rst` is high at a clock edge, the next cycle shows `mode_clk`, `done`, `cfg_err` and every bit of `cfg_word` low, and `big_endian_eff` equal to `endian_pin`. The reset is synchronous.
- R2: While a load runs, `mode_clk` has a period of 256 system clocks. It is low for the first 128 clocks after the load starts and high for the next 128. It stays low whenever no load is running or the load has finished.
- R3: A load runs while `pwr_good` is high and `done` is low. `mode_din` is sampled at the clock edge where `mode_clk` rises, which is the 128th, 384th, 640th, ... edge after `pwr_good` is first seen high.
- R4: `done` rises at the edge that captures the 256th bit, which is edge 65408 of the load. It then stays high until an abort or a reset.
- R5: `cfg_word` reads all zeros while `done` is low. Once `done` is high, bit i holds the i-th captured bit, with the first bit captured landing in bit 0.
- R6: `cfg_err` is high exactly when `done` is high and at least one of `cfg_word` bits 20, 33 and 37 is 0.
- R7: `big_endian_eff` equals `cfg_word` bit 9 when `done` is high and `cfg_word` bit 8 is 1. In every other case it follows `endian_pin` in the same cycle.
- R8: `pwr_good` low at a clock edge clears the divider, the captured bits and `done`. The next load starts again from bit 0.
- R9: `cold_rst` high during a load aborts it in the same way. If `pwr_good` is still high after release, the load restarts from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| cold_rst | input | 1 | Synchronous active-high cold reset |
| pwr_good | input | 1 | Supply-stable indication; its rise starts a load |
| mode_din | input | 1 | Serial mode data from the external source |
| endian_pin | input | 1 | External big-endian selection pin |
| mode_clk | output | 1 | Divided serial clock to the mode source |
| cfg_word | output | 256 | Assembled configuration word, zero until done |
| done | output | 1 | Load complete |
| cfg_err | output | 1 | A bit that must be one was loaded as zero |
| big_endian_eff | output | 1 | Effective endianness after the override rule |

## Verification
Two full loads use different 256-bit patterns. The first sets the selector bit to 1, sets the stream endian bit and has all mandatory bits at one. This shows that the pin is ignored and that no error is raised. The second clears the selector bit and one mandatory bit, which shows the pin taking over and the error flag rising. The endian pin toggles throughout both loads, so an endian output tied to the wrong source is caught. A partial load is cut short by dropping power-good, and another is cut short by cold reset. Each interruption must leave nothing behind, and the load that follows must count its 65408 edges from zero.

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader #(
  parameter int STREAM_BITS    = 256,
  parameter int DIV_BITS       = 8,
  parameter int ENDIAN_SEL_POS = 8,
  parameter int ENDIAN_VAL_POS = 9,
  parameter int ONE_POS_A      = 20,
  parameter int ONE_POS_B      = 33,
  parameter int ONE_POS_C      = 37
) (
  input  logic                   clk,
  input  logic                   cold_rst,
  input  logic                   pwr_good,
  input  logic                   mode_din,
  input  logic                   endian_pin,
  output logic                   mode_clk,
  output logic [STREAM_BITS-1:0] cfg_word,
  output logic                   done,
  output logic                   cfg_err,
  output logic                   big_endian_eff
);
  localparam int CNT_W = $clog2(STREAM_BITS);
  localparam logic [DIV_BITS-1:0] SAMPLE_PH = DIV_BITS'((1 << (DIV_BITS-1)) - 1);
  localparam logic [CNT_W-1:0]    LAST_BIT  = CNT_W'(STREAM_BITS - 1);

  logic [DIV_BITS-1:0]    div_q;
  logic [CNT_W-1:0]       bit_q;
  logic [STREAM_BITS-1:0] shreg_q;
  logic                   done_q;

  wire run    = pwr_good & ~done_q;
  wire sample = run & (div_q == SAMPLE_PH);
  wire last   = (bit_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (cold_rst | ~pwr_good) begin
      div_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      done_q  <= 1'b0;
    end else if (run) begin
      div_q <= (sample & last) ? '0 : div_q + DIV_BITS'(1);
      if (sample) begin
        shreg_q <= {mode_din, shreg_q[STREAM_BITS-1:1]};
        bit_q   <= last ? '0 : bit_q + CNT_W'(1);
        if (last) done_q <= 1'b1;
      end
    end
  end

  assign mode_clk       = div_q[DIV_BITS-1];
  assign done           = done_q;
  assign cfg_word       = done_q ? shreg_q : '0;
  assign cfg_err        = done_q & ~(shreg_q[ONE_POS_A] & shreg_q[ONE_POS_B] & shreg_q[ONE_POS_C]);
  assign big_endian_eff = (done_q & shreg_q[ENDIAN_SEL_POS]) ? shreg_q[ENDIAN_VAL_POS] : endian_pin;
endmodule

module boot_cfg_loader_chk #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         cold_rst,
  input logic         pwr_good,
  input logic         endian_pin,
  input logic         mode_clk,
  input logic [W-1:0] cfg_word,
  input logic         done,
  input logic         cfg_err,
  input logic         big_endian_eff
);
  // R2
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (cold_rst)
    done |-> !mode_clk);

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (cold_rst)
    (done && pwr_good) |=> done);

  // R8
  abort_clear_chk: assert property (@(posedge clk) disable iff (cold_rst)
    !pwr_good |=> (!done && !mode_clk));

  // R5
  word_hidden_chk: assert property (@(posedge clk) disable iff (cold_rst)
    !done |-> (cfg_word == '0));

  // R6
  err_needs_done_chk: assert property (@(posedge clk) disable iff (cold_rst)
    cfg_err |-> done);

  // R7
  pin_passthru_chk: assert property (@(posedge clk) disable iff (cold_rst)
    !done |-> (big_endian_eff == endian_pin));

  // R3
  finish_on_sample_chk: assert property (@(posedge clk) disable iff (cold_rst)
    $rose(done) |-> !$past(mode_clk));
endmodule

bind boot_cfg_loader boot_cfg_loader_chk #(.W(STREAM_BITS)) u_chk (
  .clk(clk), .cold_rst(cold_rst), .pwr_good(pwr_good), .endian_pin(endian_pin),
  .mode_clk(mode_clk), .cfg_word(cfg_word), .done(done), .cfg_err(cfg_err),
  .big_endian_eff(big_endian_eff)
);

// File: tb/boot_cfg_loader_bench.sv
module boot_cfg_loader_bench;
  logic clk = 1'b0;
  logic cold_rst = 1'b1, pwr_good = 1'b0, mode_din = 1'b0, endian_pin = 1'b0;
  logic mode_clk, done, cfg_err, big_endian_eff;
  logic [255:0] cfg_word;

  int checks = 0, errors = 0;
  int phase = 0;
  bit q[$];
  bit mdone = 1'b0;
  logic [255:0] mword = '0;
  logic [255:0] pat = '0;
  longint cyc = 0;

  always #2 clk = ~clk;

  boot_cfg_loader u_boot_cfg_loader (
    .clk(clk), .cold_rst(cold_rst), .pwr_good(pwr_good), .mode_din(mode_din),
    .endian_pin(endian_pin), .mode_clk(mode_clk), .cfg_word(cfg_word),
    .done(done), .cfg_err(cfg_err), .big_endian_eff(big_endian_eff)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    logic e_clk, e_err, e_end;
    logic [255:0] e_word;
    e_clk  = (phase >= 128);
    e_word = mdone ? mword : '0;
    e_err  = mdone && !(mword[20] && mword[33] && mword[37]);
    e_end  = (mdone && mword[8]) ? mword[9] : endian_pin;
    chk(mode_clk === e_clk, "R2 mode_clk", 256'(mode_clk), 256'(e_clk));
    chk(done === mdone, "R4 done", 256'(done), 256'(mdone));
    chk(cfg_word === e_word, "R5 cfg_word", cfg_word, e_word);
    chk(cfg_err === e_err, "R6 cfg_err", 256'(cfg_err), 256'(e_err));
    chk(big_endian_eff === e_end, "R7 big_endian_eff", 256'(big_endian_eff), 256'(e_end));
  endtask

  task automatic tick();
    @(posedge clk);
    cyc++;
    if (cold_rst || !pwr_good) begin
      phase = 0; q.delete(); mdone = 1'b0; mword = '0;
    end else if (!mdone) begin
      if (phase == 127) begin
        q.push_back(mode_din);
        if (q.size() == 256) begin
          mdone = 1'b1; phase = 0;
          for (int i = 0; i < 256; i++) mword[i] = q[i];
        end else phase++;
      end else phase = (phase + 1) % 256;
    end
    @(negedge clk);
    compare_all();
    if (cyc % 777 == 0) endian_pin = ~endian_pin;
    mode_din = (q.size() < 256) ? pat[q.size()] : 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load_full(input string tag);
    int n;
    n = 0;
    while (!done && n < 70000) begin tick(); n++; end
    // R3: completion lands on the 65408th edge
    chk(n == 65408, {tag, " R3 edge count"}, 256'(n), 256'(65408));
  endtask

  initial begin
    #(4 * 195000);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    pat = {4{64'hA5C3_1E7F_0B96_D248}};
    pat[20] = 1'b1; pat[33] = 1'b1; pat[37] = 1'b1; pat[8] = 1'b1; pat[9] = 1'b1;
    @(negedge clk);
    run(5);
    // R1
    chk(done === 1'b0 && cfg_word === '0 && mode_clk === 1'b0 && cfg_err === 1'b0,
        "R1 reset state", {cfg_word[252:0], done, mode_clk, cfg_err}, '0);
    chk(big_endian_eff === endian_pin, "R1 endian follows pin", 256'(big_endian_eff), 256'(endian_pin));
    cold_rst = 1'b0;
    run(3);
    pwr_good = 1'b1;
    run(3000);
    pwr_good = 1'b0;
    run(2);
    // R8
    chk(done === 1'b0 && mode_clk === 1'b0 && cfg_word === '0, "R8 abort by power-good",
        {cfg_word[253:0], done, mode_clk}, '0);
    pwr_good = 1'b1;
    load_full("load A");
    chk(cfg_word === pat, "R5 load A word", cfg_word, pat);
    chk(cfg_err === 1'b0, "R6 load A no error", 256'(cfg_err), 256'(0));
    endian_pin = 1'b0; run(1);
    chk(big_endian_eff === 1'b1, "R7 stream wins, pin 0", 256'(big_endian_eff), 256'(1));
    endian_pin = 1'b1; run(1);
    chk(big_endian_eff === 1'b1, "R7 stream wins, pin 1", 256'(big_endian_eff), 256'(1));
    run(300);
    // R4
    chk(done === 1'b1 && mode_clk === 1'b0, "R4 done holds, clock idle", {254'(0), done, mode_clk}, 256'(2));

    pwr_good = 1'b0;
    run(2);
    pat = {4{64'h3C69_F0E1_2D87_B45A}};
    pat[20] = 1'b1; pat[33] = 1'b1; pat[37] = 1'b0; pat[8] = 1'b0;
    pwr_good = 1'b1;
    run(1000);
    cold_rst = 1'b1;
    run(2);
    // R9
    chk(done === 1'b0 && mode_clk === 1'b0 && cfg_word === '0, "R9 abort by cold reset",
        {cfg_word[253:0], done, mode_clk}, '0);
    cold_rst = 1'b0;
    load_full("load B");
    chk(cfg_word === pat, "R5 load B word", cfg_word, pat);
    chk(cfg_err === 1'b1, "R6 bit 37 zero flags error", 256'(cfg_err), 256'(1));
    endian_pin = 1'b1; run(1);
    chk(big_endian_eff === 1'b1, "R7 pin selected, pin 1", 256'(big_endian_eff), 256'(1));
    endian_pin = 1'b0; run(1);
    chk(big_endian_eff === 1'b0, "R7 pin selected, pin 0", 256'(big_endian_eff), 256'(0));
    run(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule